// File: doc/BRIEF.md
# Half-Bridge Gate Enable Sequencer with Input Filter and Deadtime

This block drives one leg of a three-phase bridge. It takes two active-low switch commands, one for the upper switch and one for the lower switch, and produces two active-high gate enables. A full bridge uses three copies of the block. Level shifting, bootstrap supplies and drive strength are outside this block.

Each command first passes a pulse-width filter. A command change takes effect only after it has held steady for `FILT_CYC` consecutive clocks, so short glitches are dropped. Turning a switch off takes effect on the clock after the filtered command drops. Turning a switch on waits until the opposite gate has been low for `DEAD_CYC` clocks. This gives the same deadtime in both directions. If both filtered commands ask for on, both gates stay off. A global disable from the fault supervisor pulls both gates low at once, without waiting for a clock.

At a 100 MHz clock the defaults give a filter of 33 cycles (330 ns) and a deadtime of 23 cycles (230 ns). All inputs are synchronous to `clk`.

Top module: `hb_deadtime_filter`

## Requirements
- R1: The command inputs are active low. When `hi_cmd_n` is held low and `lo_cmd_n` high, `hi_gate` goes high and `lo_gate` stays low. The same holds with the two sides swapped.
- R2: A change on either command input that lasts fewer than `FILT_CYC` consecutive clocks has no effect on either gate. This applies to on-pulses and to off-pulses.
- R3: A command change that holds for exactly `FILT_CYC` clocks is accepted. When no deadtime wait is pending, the gate changes `FILT_CYC+1` clock edges after the first edge that samples the new level.
- R4: Turn-off takes no deadtime. A gate falls `FILT_CYC+1` edges after its command is released, and it stays high until then.
- R5: A gate turns on only after the opposite gate has been low for `DEAD_CYC` clocks. When the request is already pending, it turns on exactly `DEAD_CYC` edges after the opposite gate fell. This holds for low-to-high and for high-to-low transitions.
- R6: `hi_gate` and `lo_gate` are never high in the same cycle.
- R7: When both filtered commands request on, both gates are driven low. A gate that was already on is turned off.
- R8: While `drive_disable` is high, both gates are low in that same cycle, and any command is ignored. After release, a gate whose command is still held returns high on the next clock edge.
- R9: During reset both gates are low. After reset the deadtime counts as already expired, so the first turn-on waits only for the filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd_n | input | 1 | Upper switch command, active low |
| lo_cmd_n | input | 1 | Lower switch command, active low |
| drive_disable | input | 1 | Global disable from the fault supervisor, active high |
| hi_gate | output | 1 | Upper switch gate enable, active high |
| lo_gate | output | 1 | Lower switch gate enable, active high |

## Verification
The bench probes the filter boundary with pulses of `FILT_CYC-1` and exactly `FILT_CYC` clocks. A design off by one would either pass the glitch or drop the legal pulse. It swaps the commands in both directions and samples one cycle either side of the expected turn-on edge. It also starts the second command a few cycles after the first is released, which catches a deadtime that is measured from the command instead of from the opposite gate falling. Further cases cover:
- both commands on together, where a design without the conflict rule would shoot through;
- disable asserted mid-pulse, where a registered disable would leave the gate on for one extra cycle;
- the first turn-on after reset, where a counter preloaded to zero would add a spurious deadtime.

// File: rtl/hb_deadtime_filter.sv
module hb_deadtime_filter #(
  parameter int FILT_CYC = 33,
  parameter int DEAD_CYC = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd_n,
  input  logic lo_cmd_n,
  input  logic drive_disable,
  output logic hi_gate,
  output logic lo_gate
);

  localparam int FCW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam int DCW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [FCW-1:0] FLAST = FCW'(FILT_CYC - 1);
  localparam logic [DCW-1:0] DLAST = DCW'(DEAD_CYC - 1);

  // index 0: upper switch, index 1: lower switch
  logic [1:0] req, filt, gate_q, off_done;

  assign req = {~lo_cmd_n, ~hi_cmd_n};

  for (genvar i = 0; i < 2; i++) begin : g_side
    logic [FCW-1:0] fcnt;
    logic           f_r;
    logic [DCW-1:0] off_cnt;
    logic           g_r;
    logic           want;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fcnt <= '0;
        f_r  <= 1'b0;
      end else if (req[i] == f_r) begin
        fcnt <= '0;
      end else if (fcnt == FLAST) begin
        fcnt <= '0;
        f_r  <= req[i];
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        off_cnt <= DLAST;
      else if (g_r)
        off_cnt <= '0;
      else if (off_cnt != DLAST)
        off_cnt <= off_cnt + 1'b1;
    end

    assign want = filt[i] & ~filt[1-i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        g_r <= 1'b0;
      else if (drive_disable || !want)
        g_r <= 1'b0;
      else if (!g_r && off_done[1-i])
        g_r <= 1'b1;
    end

    assign filt[i]     = f_r;
    assign gate_q[i]   = g_r;
    assign off_done[i] = ~g_r & (off_cnt == DLAST);
  end

  assign hi_gate = gate_q[0] & ~drive_disable;
  assign lo_gate = gate_q[1] & ~drive_disable;

endmodule

// File: rtl/hb_deadtime_filter_chk.sv
module hb_deadtime_filter_chk #(
  parameter int FILT_CYC = 33,
  parameter int DEAD_CYC = 23
) (
  input logic clk,
  input logic rst_n,
  input logic hi_cmd_n,
  input logic lo_cmd_n,
  input logic drive_disable,
  input logic hi_gate,
  input logic lo_gate
);

  localparam int RW = $clog2(FILT_CYC + 1);
  localparam int LW = $clog2(DEAD_CYC + 1);

  logic [RW-1:0] hi_run, lo_run;
  logic [LW-1:0] hi_low, lo_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      hi_low <= LW'(DEAD_CYC);
      lo_low <= LW'(DEAD_CYC);
    end else begin
      hi_run <= hi_cmd_n ? '0 : ((hi_run == RW'(FILT_CYC)) ? hi_run : hi_run + 1'b1);
      lo_run <= lo_cmd_n ? '0 : ((lo_run == RW'(FILT_CYC)) ? lo_run : lo_run + 1'b1);
      hi_low <= hi_gate ? '0 : ((hi_low == LW'(DEAD_CYC)) ? hi_low : hi_low + 1'b1);
      lo_low <= lo_gate ? '0 : ((lo_low == LW'(DEAD_CYC)) ? lo_low : lo_low + 1'b1);
    end
  end

  a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));

  a_r8_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    drive_disable |-> (!hi_gate && !lo_gate));

  a_r5_hi_deadtime: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> (lo_low >= LW'(DEAD_CYC)));

  a_r5_lo_deadtime: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_gate) |-> (hi_low >= LW'(DEAD_CYC)));

  a_r2_hi_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_gate) && !$past(drive_disable)) |-> ($past(hi_run) >= RW'(FILT_CYC)));

  a_r2_lo_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_gate) && !$past(drive_disable)) |-> ($past(lo_run) >= RW'(FILT_CYC)));

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r9_reset_low: assert (!hi_gate && !lo_gate);
    end
  end

endmodule

bind hb_deadtime_filter hb_deadtime_filter_chk #(
  .FILT_CYC(FILT_CYC),
  .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .hi_cmd_n(hi_cmd_n),
  .lo_cmd_n(lo_cmd_n),
  .drive_disable(drive_disable),
  .hi_gate(hi_gate),
  .lo_gate(lo_gate)
);

// File: tb/hb_deadtime_filter_bench.sv
module hb_deadtime_filter_bench;

  localparam int F = 33;
  localparam int D = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_cmd_n = 1'b1;
  logic lo_cmd_n = 1'b1;
  logic drive_disable = 1'b0;
  logic hi_gate, lo_gate;

  int n_chk = 0;
  int n_fail = 0;
  bit overlap = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_deadtime_filter #(.FILT_CYC(F), .DEAD_CYC(D)) u_hb_deadtime_filter (
    .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
    .drive_disable(drive_disable), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  always @(negedge clk) if (rst_n && hi_gate && lo_gate) overlap = 1'b1;

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    hi_cmd_n = 1'b1;
    lo_cmd_n = 1'b1;
    drive_disable = 1'b0;
    step(F + D + 5);
  endtask

  task automatic t_reset();
    step(2);
    chk("R9 reset hi_gate", hi_gate, 1'b0);
    chk("R9 reset lo_gate", lo_gate, 1'b0);
    rst_n = 1'b1;
    step(1);
    hi_cmd_n = 1'b0;
    step(F);
    chk("R9 first turn-on not early", hi_gate, 1'b0);
    step(1);
    chk("R9 first turn-on without deadtime", hi_gate, 1'b1);
    chk("R1 hi side out of phase, lo off", lo_gate, 1'b0);
    idle();
  endtask

  task automatic t_glitch();
    bit seen = 1'b0;
    hi_cmd_n = 1'b0;
    step(F - 1);
    hi_cmd_n = 1'b1;
    for (int k = 0; k < 2 * F; k++) begin
      step(1);
      if (hi_gate) seen = 1'b1;
    end
    chk("R2 short hi on-pulse rejected", seen, 1'b0);
    seen = 1'b0;
    lo_cmd_n = 1'b0;
    step(F - 1);
    lo_cmd_n = 1'b1;
    for (int k = 0; k < 2 * F; k++) begin
      step(1);
      if (lo_gate) seen = 1'b1;
    end
    chk("R2 short lo on-pulse rejected", seen, 1'b0);
    hi_cmd_n = 1'b0;
    step(F + 1);
    chk("R1 hi held on", hi_gate, 1'b1);
    seen = 1'b0;
    hi_cmd_n = 1'b1;
    step(F - 1);
    hi_cmd_n = 1'b0;
    for (int k = 0; k < 2 * F; k++) begin
      step(1);
      if (!hi_gate) seen = 1'b1;
    end
    chk("R2 short off-pulse rejected", seen, 1'b0);
    idle();
  endtask

  task automatic t_exact();
    hi_cmd_n = 1'b0;
    step(F);
    hi_cmd_n = 1'b1;
    chk("R3 not on before latency", hi_gate, 1'b0);
    step(1);
    chk("R3 exact-length pulse accepted", hi_gate, 1'b1);
    step(F - 1);
    chk("R4 still on before off latency", hi_gate, 1'b1);
    step(1);
    chk("R4 off after filter", hi_gate, 1'b0);
    idle();
  endtask

  task automatic t_swap();
    lo_cmd_n = 1'b0;
    step(F + 1);
    chk("R1 lo side on", lo_gate, 1'b1);
    chk("R1 hi side off", hi_gate, 1'b0);
    lo_cmd_n = 1'b1;
    hi_cmd_n = 1'b0;
    step(F);
    chk("R4 lo held until filter", lo_gate, 1'b1);
    step(1);
    chk("R4 lo off", lo_gate, 1'b0);
    step(D - 1);
    chk("R5 hi waits deadtime", hi_gate, 1'b0);
    step(1);
    chk("R5 hi on after deadtime", hi_gate, 1'b1);
    hi_cmd_n = 1'b1;
    lo_cmd_n = 1'b0;
    step(F + 1);
    chk("R4 hi off", hi_gate, 1'b0);
    step(D - 1);
    chk("R5 lo waits deadtime", lo_gate, 1'b0);
    step(1);
    chk("R5 lo on after deadtime", lo_gate, 1'b1);
    idle();
  endtask

  task automatic t_delayed();
    lo_cmd_n = 1'b0;
    step(F + 5);
    lo_cmd_n = 1'b1;
    step(5);
    hi_cmd_n = 1'b0;
    step(F + D - 5);
    chk("R5 deadtime measured from lo fall", hi_gate, 1'b0);
    step(1);
    chk("R5 hi on deadtime after lo fall", hi_gate, 1'b1);
    idle();
    lo_cmd_n = 1'b0;
    step(F + 5);
    lo_cmd_n = 1'b1;
    step(F + D + 10);
    hi_cmd_n = 1'b0;
    step(F + 1);
    chk("R5 no extra wait once expired", hi_gate, 1'b1);
    idle();
  endtask

  task automatic t_both();
    hi_cmd_n = 1'b0;
    lo_cmd_n = 1'b0;
    step(3 * F);
    chk("R7 both requested hi off", hi_gate, 1'b0);
    chk("R7 both requested lo off", lo_gate, 1'b0);
    lo_cmd_n = 1'b1;
    step(F + 1);
    chk("R7 hi on once conflict ends", hi_gate, 1'b1);
    lo_cmd_n = 1'b0;
    step(F + 1);
    chk("R7 on gate dropped by conflict", hi_gate, 1'b0);
    step(2 * F);
    chk("R7 lo stays off in conflict", lo_gate, 1'b0);
    idle();
  endtask

  task automatic t_disable();
    hi_cmd_n = 1'b0;
    step(F + 3);
    chk("R1 hi on before disable", hi_gate, 1'b1);
    drive_disable = 1'b1;
    #1;
    chk("R8 disable same cycle", hi_gate, 1'b0);
    step(3);
    chk("R8 stays low while disabled", hi_gate, 1'b0);
    drive_disable = 1'b0;
    #1;
    chk("R8 low until next edge", hi_gate, 1'b0);
    step(1);
    chk("R8 resumes on next edge", hi_gate, 1'b1);
    drive_disable = 1'b1;
    hi_cmd_n = 1'b1;
    lo_cmd_n = 1'b0;
    step(3 * F);
    chk("R8 lo command ignored while disabled", lo_gate, 1'b0);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_exact();
    t_swap();
    t_delayed();
    t_both();
    t_disable();
    chk("R6 gates never overlapped", overlap, 1'b0);
    finish_run();
  end

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule